// File: doc/BRIEF.md
# Retire and Redirect Controller

This block is the retire stage of an out-of-order core. In each cycle it looks at a window of the oldest entries of the reorder buffer for one thread. The thread is chosen outside the block. The block retires up to `COMMIT_WIDTH` of those entries in program order. It stops at the first entry that is not valid or not yet complete. An instruction that must not run speculatively is held until it sits in the oldest slot. Its sequence number is then sent back to the earlier stages, so that they can issue it. Only one such release is made per cycle, and the same instruction is never released twice in a row.

Execution units raise redirect requests. The block filters these by age against a per-thread register that holds the sequence number of the youngest live instruction. Dispatch raises this register, and every accepted squash lowers it to the squash point. When several requests arrive together, the oldest one wins. The winner is broadcast one cycle later to all earlier stages, together with its mispredict target.

Traps are scheduled a programmable number of cycles ahead, and a fired trap squash takes priority over redirects. Each thread carries one of five states: idle, running, squashing the buffer, trap pending, or fetch-trap pending. A registered activity flag summarises all threads.

Top module: `commit_redirect_ctrl`

## Requirements
- R1: `retire_mask` is a contiguous run of ones starting at slot 0, of at most `COMMIT_WIDTH` bits. Slot i is set only if every slot from 0 to i is valid and done. A slot i greater than 0 that is marked non-speculative also ends the run. `retire_cnt` equals the number of ones in the mask.
- R2: Retirement happens only when the state of the head thread is running (1) or fetch-trap pending (4). In the states idle (0), squashing (2) and trap pending (3), `retire_mask` is 0.
- R3: Suppose the head thread may retire, and slot 0 is valid, non-speculative and not done. Then `rel_valid` is high in the next cycle, carrying `head_seq` and `head_tid`. A done non-speculative instruction in slot 0 retires in the normal way.
- R4: The same sequence number is not released again while it is still the most recent release. So two successive releases always carry different numbers, and there is at most one release per cycle.
- R5: Three conditions make a redirect request eligible. Its thread must be running, squashing or fetch-trap pending. Its sequence number must be strictly older than that thread's youngest-valid register. No trap squash may fire in the same cycle. An accepted squash sets the youngest-valid register to the squash sequence number.
- R6: Among eligible requests in one cycle, the oldest wins, with ties going to the lowest request index. Number a is older than b when bit `SEQ_W-1` of (a - b) mod 2^SEQ_W is set.
- R7: The squash chosen in a cycle shows up on `sq_valid`, `sq_tid`, `sq_seq`, `sq_mispred` and `sq_target` after the next clock edge. The same edge puts the squashed thread into the squashing state (2).
- R8: After reset every thread is idle (0) with a youngest-valid value of 0. An allocation moves an idle thread to running (1). In any state, an allocation sets the youngest-valid register to `alloc_seq`, unless a squash hits that thread in the same cycle.
- R9: A trap accepted with delay d fires when its countdown reaches zero. The thread's trap squash then appears on the squash outputs d+1 cycles after the thread enters trap pending (3). It carries `trap_seq` with the mispredict flag and target at 0. When several threads fire together, the lowest thread goes first. Any thread still waiting retries in the next cycle.
- R10: A trap with `trap_fetch` set enters fetch-trap pending (4). The thread stays there until a cycle in which it is the head thread and `head_valid` is all zero. It then moves to trap pending with the delay it was given.
- R11: A squashing thread returns to running when its bit of `rob_squash_done` is high, unless a new squash hits that thread in the same cycle.
- R12: `stage_active` equals, one cycle late, whether any thread was not idle.
- R13: A trap request for a thread that is not running has no effect on its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_tid | input | TID_W | Thread owning the head window this cycle |
| head_valid | input | COMMIT_WIDTH | Head slot holds an instruction |
| head_done | input | COMMIT_WIDTH | Head slot has completed |
| head_nonspec | input | COMMIT_WIDTH | Head slot is non-speculative |
| head_seq | input | SEQ_W | Sequence number of slot 0 |
| alloc_valid | input | 1 | An instruction entered the buffer |
| alloc_tid | input | TID_W | Thread of the allocation |
| alloc_seq | input | SEQ_W | Sequence number of the allocation |
| redir_req | input | NUM_REDIR | Redirect request per source |
| redir_tid | input | NUM_REDIR*TID_W | Thread per request |
| redir_seq | input | NUM_REDIR*SEQ_W | Squash point per request |
| redir_mispred | input | NUM_REDIR | Request is a branch mispredict |
| redir_target | input | NUM_REDIR*ADDR_W | Corrected fetch address per request |
| trap_req | input | 1 | Trap or interrupt request |
| trap_fetch | input | 1 | Trap must wait for the buffer to drain |
| trap_tid | input | TID_W | Thread of the trap |
| trap_seq | input | SEQ_W | Squash point of the trap |
| trap_delay | input | DLY_W | Cycles before the trap squash fires |
| rob_squash_done | input | NUM_THREADS | Buffer has finished squashing, per thread |
| retire_mask | output | COMMIT_WIDTH | Head slots retired this cycle |
| retire_cnt | output | CNT_W | Number of slots retired |
| rel_valid | output | 1 | Non-speculative release strobe |
| rel_tid | output | TID_W | Thread of the release |
| rel_seq | output | SEQ_W | Sequence number released |
| sq_valid | output | 1 | Squash broadcast strobe |
| sq_tid | output | TID_W | Thread being squashed |
| sq_seq | output | SEQ_W | Squash everything younger than this |
| sq_mispred | output | 1 | Broadcast comes from a mispredict |
| sq_target | output | ADDR_W | Redirect address |
| thread_state | output | NUM_THREADS*3 | State code per thread |
| stage_active | output | 1 | Some thread is not idle |

## Verification
On every cycle the assertions check the following. The retire mask forms a prefix of completed slots and stays zero while the head thread is blocked. A broadcast squash has already lowered the youngest-valid register and left its thread squashing. Two successive releases never repeat a number, and the activity flag follows the thread states. Other behaviour shows only in the bench's random scenarios, which run against a behavioural model: which request wins across wrap-around sequence numbers, trap countdown timing and priority between threads, the fetch-trap drain condition, and trap requests dropped outside the running state.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_ROBSQ = 3'd2,
    TS_TRAP  = 3'd3,
    TS_FTRAP = 3'd4
  } tstate_e;

  // a is older than b when (a - b) mod 2^w has its top bit set
  function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [63:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/crc_retire_sel.sv
module crc_retire_sel #(
  parameter int W  = 4,
  parameter int CW = 3
) (
  input  logic          en,
  input  logic [W-1:0]  hv,
  input  logic [W-1:0]  hd,
  input  logic [W-1:0]  hns,
  output logic [W-1:0]  ret,
  output logic [CW-1:0] cnt,
  output logic          ns_wait
);
  logic ok;

  always_comb begin
    ok  = en;
    ret = '0;
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      ok = ok & hv[i] & hd[i] & (~hns[i] | (i == 0));
      ret[i] = ok;
      if (ok) cnt = cnt + CW'(1);
    end
  end

  assign ns_wait = en & hv[0] & hns[0] & ~hd[0];
endmodule

// File: rtl/crc_redirect_pick.sv
module crc_redirect_pick import crc_pkg::*; #(
  parameter int N     = 2,
  parameter int SEQ_W = 16,
  parameter int IW    = 1
) (
  input  logic [N-1:0]       elig,
  input  logic [N*SEQ_W-1:0] seqs,
  output logic               found,
  output logic [IW-1:0]      idx
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found ||
          seq_older(64'(seqs[i*SEQ_W +: SEQ_W]), 64'(best), SEQ_W))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = seqs[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/crc_thread_ctl.sv
module crc_thread_ctl import crc_pkg::*; #(
  parameter int SEQ_W = 16,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             trap_hit,
  input  logic             trap_fetch,
  input  logic [SEQ_W-1:0] trap_seq,
  input  logic [DLY_W-1:0] trap_dly,
  input  logic             head_empty,
  input  logic             rob_done,
  input  logic             sq_hit,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [2:0]       state,
  output logic [SEQ_W-1:0] young,
  output logic [SEQ_W-1:0] tseq,
  output logic             fire,
  output logic             can_retire,
  output logic             can_redirect
);
  tstate_e          st_q;
  logic [SEQ_W-1:0] young_q;
  logic [SEQ_W-1:0] tseq_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= TS_IDLE;
      young_q <= '0;
      tseq_q  <= '0;
      cnt_q   <= '0;
    end else if (sq_hit) begin
      st_q    <= TS_ROBSQ;
      young_q <= sq_seq;
    end else begin
      if (alloc_hit) young_q <= alloc_seq;
      case (st_q)
        TS_IDLE:  if (alloc_hit) st_q <= TS_RUN;
        TS_RUN: if (trap_hit) begin
          st_q   <= trap_fetch ? TS_FTRAP : TS_TRAP;
          cnt_q  <= trap_dly;
          tseq_q <= trap_seq;
        end
        TS_ROBSQ: if (rob_done) st_q <= TS_RUN;
        TS_TRAP:  if (cnt_q != '0) cnt_q <= cnt_q - DLY_W'(1);
        TS_FTRAP: if (head_empty) st_q <= TS_TRAP;
        default:  st_q <= TS_IDLE;
      endcase
    end
  end

  assign state        = st_q;
  assign young        = young_q;
  assign tseq         = tseq_q;
  assign fire         = (st_q == TS_TRAP) && (cnt_q == '0);
  assign can_retire   = (st_q == TS_RUN) || (st_q == TS_FTRAP);
  assign can_redirect = (st_q == TS_RUN) || (st_q == TS_ROBSQ) || (st_q == TS_FTRAP);
endmodule

// File: rtl/commit_redirect_ctrl.sv
module commit_redirect_ctrl import crc_pkg::*; #(
  parameter int NUM_THREADS  = 2,
  parameter int COMMIT_WIDTH = 4,
  parameter int NUM_REDIR    = 2,
  parameter int SEQ_W        = 16,
  parameter int ADDR_W       = 32,
  parameter int DLY_W        = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W = $clog2(COMMIT_WIDTH + 1),
  localparam int RI_W  = (NUM_REDIR > 1) ? $clog2(NUM_REDIR) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TID_W-1:0]              head_tid,
  input  logic [COMMIT_WIDTH-1:0]       head_valid,
  input  logic [COMMIT_WIDTH-1:0]       head_done,
  input  logic [COMMIT_WIDTH-1:0]       head_nonspec,
  input  logic [SEQ_W-1:0]              head_seq,
  input  logic                          alloc_valid,
  input  logic [TID_W-1:0]              alloc_tid,
  input  logic [SEQ_W-1:0]              alloc_seq,
  input  logic [NUM_REDIR-1:0]          redir_req,
  input  logic [NUM_REDIR*TID_W-1:0]    redir_tid,
  input  logic [NUM_REDIR*SEQ_W-1:0]    redir_seq,
  input  logic [NUM_REDIR-1:0]          redir_mispred,
  input  logic [NUM_REDIR*ADDR_W-1:0]   redir_target,
  input  logic                          trap_req,
  input  logic                          trap_fetch,
  input  logic [TID_W-1:0]              trap_tid,
  input  logic [SEQ_W-1:0]              trap_seq,
  input  logic [DLY_W-1:0]              trap_delay,
  input  logic [NUM_THREADS-1:0]        rob_squash_done,
  output logic [COMMIT_WIDTH-1:0]       retire_mask,
  output logic [CNT_W-1:0]              retire_cnt,
  output logic                          rel_valid,
  output logic [TID_W-1:0]              rel_tid,
  output logic [SEQ_W-1:0]              rel_seq,
  output logic                          sq_valid,
  output logic [TID_W-1:0]              sq_tid,
  output logic [SEQ_W-1:0]              sq_seq,
  output logic                          sq_mispred,
  output logic [ADDR_W-1:0]             sq_target,
  output logic [NUM_THREADS*3-1:0]      thread_state,
  output logic                          stage_active
);
  // per-thread views
  logic [2:0]       state_vec [NUM_THREADS];
  logic [SEQ_W-1:0] young_vec [NUM_THREADS];
  logic [SEQ_W-1:0] tseq_vec  [NUM_THREADS];
  logic [NUM_THREADS-1:0] fire_vec, retire_ok, redir_ok, sq_hit;

  // named internal events
  logic                 head_ok, ns_wait, rel_fire;
  logic [2:0]           head_state, sq_tid_state;
  logic [SEQ_W-1:0]     sq_tid_young;
  logic                 any_busy;
  logic [NUM_REDIR-1:0] req_elig;
  logic                 redir_found, trap_take, sq_take;
  logic [RI_W-1:0]      pick_idx;
  logic [TID_W-1:0]     trap_idx, n_tid;
  logic [SEQ_W-1:0]     n_seq;
  logic                 n_mis;
  logic [ADDR_W-1:0]    n_tgt;
  logic                 last_vld;
  logic [SEQ_W-1:0]     last_seq;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    crc_thread_ctl #(.SEQ_W(SEQ_W), .DLY_W(DLY_W)) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_hit    (alloc_valid && (alloc_tid == TID_W'(t))),
      .alloc_seq    (alloc_seq),
      .trap_hit     (trap_req && (trap_tid == TID_W'(t))),
      .trap_fetch   (trap_fetch),
      .trap_seq     (trap_seq),
      .trap_dly     (trap_delay),
      .head_empty   ((head_tid == TID_W'(t)) && (head_valid == '0)),
      .rob_done     (rob_squash_done[t]),
      .sq_hit       (sq_hit[t]),
      .sq_seq       (n_seq),
      .state        (state_vec[t]),
      .young        (young_vec[t]),
      .tseq         (tseq_vec[t]),
      .fire         (fire_vec[t]),
      .can_retire   (retire_ok[t]),
      .can_redirect (redir_ok[t])
    );
    assign thread_state[t*3 +: 3] = state_vec[t];
    assign sq_hit[t] = sq_take && (n_tid == TID_W'(t));
  end

  // retirement from the head window
  assign head_ok    = (int'(head_tid) < NUM_THREADS) && retire_ok[head_tid];
  assign head_state = (int'(head_tid) < NUM_THREADS) ? state_vec[head_tid] : 3'd0;

  crc_retire_sel #(.W(COMMIT_WIDTH), .CW(CNT_W)) u_ret (
    .en      (head_ok),
    .hv      (head_valid),
    .hd      (head_done),
    .hns     (head_nonspec),
    .ret     (retire_mask),
    .cnt     (retire_cnt),
    .ns_wait (ns_wait)
  );

  // non-speculative release, one per cycle, no repeat
  assign rel_fire = ns_wait && !(last_vld && (last_seq == head_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid <= 1'b0;
      rel_tid   <= '0;
      rel_seq   <= '0;
      last_vld  <= 1'b0;
      last_seq  <= '0;
    end else begin
      rel_valid <= rel_fire;
      rel_tid   <= head_tid;
      rel_seq   <= head_seq;
      if (rel_fire) begin
        last_vld <= 1'b1;
        last_seq <= head_seq;
      end
    end
  end

  // redirect age filter
  for (genvar r = 0; r < NUM_REDIR; r++) begin : g_req
    logic [TID_W-1:0] rt;
    logic [SEQ_W-1:0] rs;
    assign rt = redir_tid[r*TID_W +: TID_W];
    assign rs = redir_seq[r*SEQ_W +: SEQ_W];
    assign req_elig[r] = redir_req[r] && (int'(rt) < NUM_THREADS) && redir_ok[rt] &&
                         seq_older(64'(rs), 64'(young_vec[rt]), SEQ_W);
  end

  crc_redirect_pick #(.N(NUM_REDIR), .SEQ_W(SEQ_W), .IW(RI_W)) u_pick (
    .elig  (req_elig),
    .seqs  (redir_seq),
    .found (redir_found),
    .idx   (pick_idx)
  );

  // trap fire grant: lowest thread first
  always_comb begin
    trap_take = 1'b0;
    trap_idx  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (fire_vec[t] && !trap_take) begin
        trap_take = 1'b1;
        trap_idx  = TID_W'(t);
      end
    end
  end

  // squash source select: trap beats redirect
  assign sq_take = trap_take | redir_found;

  always_comb begin
    if (trap_take) begin
      n_tid = trap_idx;
      n_seq = tseq_vec[trap_idx];
      n_mis = 1'b0;
      n_tgt = '0;
    end else begin
      n_tid = redir_tid[pick_idx*TID_W +: TID_W];
      n_seq = redir_seq[pick_idx*SEQ_W +: SEQ_W];
      n_mis = redir_mispred[pick_idx];
      n_tgt = redir_target[pick_idx*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_valid   <= 1'b0;
      sq_tid     <= '0;
      sq_seq     <= '0;
      sq_mispred <= 1'b0;
      sq_target  <= '0;
    end else begin
      sq_valid   <= sq_take;
      sq_tid     <= n_tid;
      sq_seq     <= n_seq;
      sq_mispred <= n_mis;
      sq_target  <= n_tgt;
    end
  end

  // overall activity, settled at the end of the cycle
  always_comb begin
    any_busy = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (state_vec[t] != 3'd0) any_busy = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage_active <= 1'b0;
    else        stage_active <= any_busy;
  end

  assign sq_tid_state = state_vec[sq_tid];
  assign sq_tid_young = young_vec[sq_tid];
endmodule

// File: rtl/crc_checker.sv
module crc_checker import crc_pkg::*; #(
  parameter int W     = 4,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     retire_mask,
  input logic [W-1:0]     head_valid,
  input logic [W-1:0]     head_done,
  input logic [2:0]       head_state,
  input logic             rel_valid,
  input logic [SEQ_W-1:0] rel_seq,
  input logic             sq_valid,
  input logic [SEQ_W-1:0] sq_seq,
  input logic [2:0]       sq_tid_state,
  input logic [SEQ_W-1:0] sq_tid_young,
  input logic             any_busy,
  input logic             stage_active
);
  // R1
  retire_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_mask & (retire_mask + W'(1))) == '0);

  // R1
  retire_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_mask & ~(head_valid & head_done)) == '0);

  // R2
  retire_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_state == TS_IDLE || head_state == TS_ROBSQ || head_state == TS_TRAP)
      |-> retire_mask == '0);

  // R4
  rel_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && $past(rel_valid)) |-> rel_seq != $past(rel_seq));

  // R5
  sq_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> sq_tid_young == sq_seq);

  // R7
  sq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> sq_tid_state == TS_ROBSQ);

  // R12
  active_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_busy |=> stage_active);

  // R12
  active_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_busy |=> !stage_active);
endmodule

bind commit_redirect_ctrl crc_checker #(.W(COMMIT_WIDTH), .SEQ_W(SEQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_mask  (retire_mask),
  .head_valid   (head_valid),
  .head_done    (head_done),
  .head_state   (head_state),
  .rel_valid    (rel_valid),
  .rel_seq      (rel_seq),
  .sq_valid     (sq_valid),
  .sq_seq       (sq_seq),
  .sq_tid_state (sq_tid_state),
  .sq_tid_young (sq_tid_young),
  .any_busy     (any_busy),
  .stage_active (stage_active)
);

// File: tb/commit_redirect_ctrl_test.sv
`timescale 1ns/1ps
module commit_redirect_ctrl_test;
  localparam int T = 2, W = 4, N = 2, SW = 16, AW = 32, DW = 4, TW = 1, CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [TW-1:0]   head_tid;
  logic [W-1:0]    head_valid, head_done, head_nonspec;
  logic [SW-1:0]   head_seq;
  logic            alloc_valid;
  logic [TW-1:0]   alloc_tid;
  logic [SW-1:0]   alloc_seq;
  logic [N-1:0]    redir_req, redir_mispred;
  logic [N*TW-1:0] redir_tid;
  logic [N*SW-1:0] redir_seq;
  logic [N*AW-1:0] redir_target;
  logic            trap_req, trap_fetch;
  logic [TW-1:0]   trap_tid;
  logic [SW-1:0]   trap_seq;
  logic [DW-1:0]   trap_delay;
  logic [T-1:0]    rob_squash_done;
  logic [W-1:0]    retire_mask;
  logic [CW-1:0]   retire_cnt;
  logic            rel_valid, sq_valid, sq_mispred, stage_active;
  logic [TW-1:0]   rel_tid, sq_tid;
  logic [SW-1:0]   rel_seq, sq_seq;
  logic [AW-1:0]   sq_target;
  logic [T*3-1:0]  thread_state;

  commit_redirect_ctrl uut (
    .clk(clk), .rst_n(rst_n), .head_tid(head_tid), .head_valid(head_valid),
    .head_done(head_done), .head_nonspec(head_nonspec), .head_seq(head_seq),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
    .redir_req(redir_req), .redir_tid(redir_tid), .redir_seq(redir_seq),
    .redir_mispred(redir_mispred), .redir_target(redir_target),
    .trap_req(trap_req), .trap_fetch(trap_fetch), .trap_tid(trap_tid),
    .trap_seq(trap_seq), .trap_delay(trap_delay), .rob_squash_done(rob_squash_done),
    .retire_mask(retire_mask), .retire_cnt(retire_cnt), .rel_valid(rel_valid),
    .rel_tid(rel_tid), .rel_seq(rel_seq), .sq_valid(sq_valid), .sq_tid(sq_tid),
    .sq_seq(sq_seq), .sq_mispred(sq_mispred), .sq_target(sq_target),
    .thread_state(thread_state), .stage_active(stage_active)
  );

  int n_chk = 0, n_fail = 0;
  int m_st[T], m_young[T], m_cnt[T], m_tseq[T], acnt[T];
  bit m_lastv;
  int m_lasts;

  function automatic bit older(int a, int b);
    int d;
    d = (a - b) & 32'hFFFF;
    return d >= 32768;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // one cycle of the reference model: inputs are already driven
  task automatic step();
    int ht, ok, emask, ecnt, ft, bi, bs, rt, rs, relc;
    int sqv, sqt, sqs, sqm, act;
    longint sqg;
    int n_st[T], n_yg[T], n_ct[T], n_ts[T];
    string tg;
    #1;
    ht = int'(head_tid);
    ok = (m_st[ht] == 1 || m_st[ht] == 4);
    tg = ok ? "R1 retire" : "R2 retire blocked";
    emask = 0; ecnt = 0;
    for (int i = 0; i < W; i++) begin
      if (!(head_valid[i] && head_done[i] && (!head_nonspec[i] || i == 0))) ok = 0;
      if (ok) begin emask |= (1 << i); ecnt++; end
    end
    chk({tg, " mask"}, 64'(retire_mask), 64'(emask));
    chk({tg, " count"}, 64'(retire_cnt), 64'(ecnt));
    // R3 release condition
    relc = (m_st[ht] == 1 || m_st[ht] == 4) && head_valid[0] && head_nonspec[0] &&
           !head_done[0] && !(m_lastv && m_lasts == int'(head_seq));
    // R9 trap fire, lowest thread first
    ft = -1;
    for (int t = 0; t < T; t++) if (ft < 0 && m_st[t] == 3 && m_cnt[t] == 0) ft = t;
    // R5 R6 oldest eligible redirect
    bi = -1; bs = 0;
    for (int r = 0; r < N; r++) begin
      rt = int'(redir_tid[r*TW +: TW]);
      rs = int'(redir_seq[r*SW +: SW]);
      if (redir_req[r] && (m_st[rt] == 1 || m_st[rt] == 2 || m_st[rt] == 4) &&
          older(rs, m_young[rt]) && (bi < 0 || older(rs, bs))) begin
        bi = r; bs = rs;
      end
    end
    sqv = 0; sqt = 0; sqs = 0; sqm = 0; sqg = 0;
    if (ft >= 0) begin
      sqv = 1; sqt = ft; sqs = m_tseq[ft];
    end else if (bi >= 0) begin
      sqv = 1; sqt = int'(redir_tid[bi*TW +: TW]); sqs = bs;
      sqm = int'(redir_mispred[bi]); sqg = longint'(redir_target[bi*AW +: AW]);
    end
    act = 0;
    for (int t = 0; t < T; t++) if (m_st[t] != 0) act = 1;
    for (int t = 0; t < T; t++) begin
      n_st[t] = m_st[t]; n_yg[t] = m_young[t]; n_ct[t] = m_cnt[t]; n_ts[t] = m_tseq[t];
      if (sqv && sqt == t) begin
        n_st[t] = 2; n_yg[t] = sqs;
      end else begin
        if (alloc_valid && int'(alloc_tid) == t) n_yg[t] = int'(alloc_seq);
        case (m_st[t])
          0: if (alloc_valid && int'(alloc_tid) == t) n_st[t] = 1;
          1: if (trap_req && int'(trap_tid) == t) begin
               n_st[t] = trap_fetch ? 4 : 3;
               n_ct[t] = int'(trap_delay);
               n_ts[t] = int'(trap_seq);
             end
          2: if (rob_squash_done[t]) n_st[t] = 1;
          3: if (n_ct[t] > 0) n_ct[t]--;
          4: if (ht == t && head_valid == '0) n_st[t] = 3;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    #1;
    chk(ft >= 0 ? "R9 trap squash valid" : "R5 squash valid", 64'(sq_valid), 64'(sqv));
    if (sqv) begin
      chk("R7 squash tid", 64'(sq_tid), 64'(sqt));
      chk("R6 squash seq", 64'(sq_seq), 64'(sqs));
      chk("R7 squash mispred", 64'(sq_mispred), 64'(sqm));
      chk("R7 squash target", 64'(sq_target), 64'(sqg));
    end
    chk("R3 release valid", 64'(rel_valid), 64'(relc));
    if (relc) begin
      chk("R4 release seq", 64'(rel_seq), 64'(head_seq));
      chk("R3 release tid", 64'(rel_tid), 64'(ht));
      m_lastv = 1; m_lasts = int'(head_seq);
    end
    for (int t = 0; t < T; t++) begin
      case (m_st[t])
        0: tg = "R8 state from idle";
        1: tg = "R13 state from running";
        2: tg = "R11 state from squashing";
        3: tg = "R9 state from trap pending";
        default: tg = "R10 state from fetch trap";
      endcase
      chk(tg, 64'(thread_state[t*3 +: 3]), 64'(n_st[t]));
      m_st[t] = n_st[t]; m_young[t] = n_yg[t]; m_cnt[t] = n_ct[t]; m_tseq[t] = n_ts[t];
    end
    chk("R12 stage active", 64'(stage_active), 64'(act));
  endtask

  initial begin
    int hold;
    head_tid = '0; head_valid = '0; head_done = '0; head_nonspec = '0; head_seq = '0;
    alloc_valid = 0; alloc_tid = '0; alloc_seq = '0;
    redir_req = '0; redir_tid = '0; redir_seq = '0; redir_mispred = '0; redir_target = '0;
    trap_req = 0; trap_fetch = 0; trap_tid = '0; trap_seq = '0; trap_delay = '0;
    rob_squash_done = '0;
    for (int t = 0; t < T; t++) begin
      m_st[t] = 0; m_young[t] = 0; m_cnt[t] = 0; m_tseq[t] = 0; acnt[t] = 16'hFFF0;
    end
    m_lastv = 0; m_lasts = 0; hold = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 reset thread states", 64'(thread_state), 64'(0));
    chk("R12 reset active", 64'(stage_active), 64'(0));
    chk("R7 reset squash", 64'(sq_valid), 64'(0));
    chk("R3 reset release", 64'(rel_valid), 64'(0));
    rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if (hold == 0) begin
        head_tid = TW'($urandom_range(0, T - 1));
        head_valid = W'($urandom_range(0, 15));
        for (int i = 0; i < W; i++) head_nonspec[i] = ($urandom_range(0, 7) == 0);
        head_seq = SW'($urandom_range(0, 65535));
        hold = $urandom_range(0, 3);
      end else hold--;
      for (int i = 0; i < W; i++) head_done[i] = ($urandom_range(0, 3) != 0);
      alloc_valid = ($urandom_range(0, 9) < 3);
      if (alloc_valid) begin
        int at;
        at = $urandom_range(0, T - 1);
        acnt[at] = (acnt[at] + 1) & 16'hFFFF;
        alloc_tid = TW'(at);
        alloc_seq = SW'(acnt[at]);
      end
      for (int r = 0; r < N; r++) begin
        int rt;
        rt = $urandom_range(0, T - 1);
        redir_req[r] = ($urandom_range(0, 3) == 0);
        redir_tid[r*TW +: TW] = TW'(rt);
        redir_seq[r*SW +: SW] = SW'((acnt[rt] - $urandom_range(0, 7) + 2) & 16'hFFFF);
        redir_mispred[r] = $urandom_range(0, 1) == 1;
        redir_target[r*AW +: AW] = $urandom;
      end
      trap_req = ($urandom_range(0, 29) == 0);
      trap_fetch = $urandom_range(0, 1) == 1;
      trap_tid = TW'($urandom_range(0, T - 1));
      trap_seq = SW'($urandom_range(0, 65535));
      trap_delay = DW'($urandom_range(0, 5));
      for (int t = 0; t < T; t++) rob_squash_done[t] = ($urandom_range(0, 2) == 0);
      step();
    end
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end
endmodule